// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the data path of a simple processor in which every register transfer uses one shared internal bus. The block holds eight general registers and six special registers: the program counter, the instruction register, the two ALU temporaries Y and Z, the memory address register and the memory data register. Each register has its own load control, and most also have a drive control. In any cycle, the external step sequencer raises one drive control, which places that register on the bus. It also raises the load controls of every register that should capture the bus value at the next clock edge.

The ALU is purely combinational. Its A operand comes from a multiplexer that picks either register Y or the constant 4; the constant is used to advance the program counter by one byte-addressed word. Its B operand is the bus. The ALU result is stored only in Z, and the negative and zero flags are captured together with Z.

The memory address register always drives the external address lines. The memory data register can load from the bus or from the external read data. Its contents always drive the external write data, and it can be driven onto the bus. External memory accesses are tracked by a small state machine:
- IDLE moves to READ on a read request. Otherwise it moves to WRITE on a write request.
- READ and WRITE each return to IDLE in the cycle the memory signals completion.

While an access is outstanding and completion has not arrived, a wait output tells the sequencer to hold its current step.

Top module: `sbus_datapath`

## Requirements
- R1: After reset, every register, both flags, the read and write strobes and the wait output are zero. A register driven onto the bus with no prior load reads as 0.
- R2: The control vector `ctl` has this layout:

  | Bits | Meaning |
  |------|---------|
  | [7:0] | General register k drive (bit k) |
  | [15:8] | General register k load (bit 8+k) |
  | 16 | PC drive |
  | 17 | PC load |
  | 18 | IR drive |
  | 19 | IR load |
  | 20 | Y load |
  | 21 | Z drive |
  | 22 | Z load |
  | 23 | MAR load |
  | 24 | MDR drive |
  | 25 | MDR load from bus |
  | 26 | MDR load from memory |
  | 27 | Read request |
  | 28 | Write request |
  | 29 | Select constant 4 |
  | [32:30] | ALU operation |

  A register whose load bit is set captures the bus at the clock edge. `bus_q` shows the bus value.
- R3: The bus carries the value of the single register whose drive bit is set, or 0 when no drive bit is set. At most one drive bit may be set in a cycle.
- R4: With select-4 set, ALU operand A is the constant 4 and not Y. Driving PC, adding and loading Z, and then moving Z to PC advances PC by 4.
- R5: The ALU computes A op B with B equal to the bus. The operation codes are: 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 pass B. Codes 5 to 7 also pass B.
- R6: Z and both flags change only on a cycle with Z load set. At that edge, N takes bit 31 of the result and the zero flag is set when the result is all zeros.
- R7: `mem_addr` always equals MAR, and MAR changes only when its load bit is set.
- R8: A read request in IDLE raises `mem_rd` from the next cycle until the cycle in which `mem_done` is seen. `mem_wait` is high in READ while `mem_done` is low. With MDR-load-from-memory set and `mem_done` high, MDR captures `mem_rdata`.
- R9: A write request in IDLE raises `mem_wr` from the next cycle until `mem_done`. During the write, `mem_wdata` presents MDR.
- R10: Requests made while an access is outstanding are ignored. When both requests arrive together in IDLE, the read is taken.
- R11: MDR loads from the bus when its bus-load bit is set. When a memory load with `mem_done` coincides with a bus load, the memory value wins.
- R12: Three steps add two general registers into a third:
  1. Move the first source to Y.
  2. Drive the second source, add and load Z.
  3. Move Z to the destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl | input | 33 | Per-step control vector (layout in R2) |
| mem_rdata | input | 32 | Read data from memory |
| mem_done | input | 1 | Memory completion for the outstanding access |
| mem_addr | output | 32 | Memory address, always MAR |
| mem_wdata | output | 32 | Write data, always MDR |
| mem_rd | output | 1 | Read strobe, held until completion |
| mem_wr | output | 1 | Write strobe, held until completion |
| mem_wait | output | 1 | Access outstanding and not yet completed |
| flag_n | output | 1 | Negative flag of the last Z load |
| flag_z | output | 1 | Zero flag of the last Z load |
| ir_q | output | 32 | Instruction register contents for the decoder |
| bus_q | output | 32 | Current internal bus value |

## Verification
The assertions rely on the sequencer setting no more than one drive bit per cycle. They also rely on the memory raising `mem_done` only while a strobe is high. The directed tasks follow both rules: each step names a single driver or none, and the bench's memory handling raises completion only after it has seen the strobe for the chosen latency. Requests issued during an outstanding access are deliberate, because the block must ignore them, and they do not break either rule.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
    localparam int NGPR  = 8;
    localparam int OP_W  = 3;

    // control vector bit positions, derived from the general register count
    localparam int C_GDRV    = 0;
    localparam int C_GLD     = NGPR;
    localparam int C_PC_DRV  = 2 * NGPR;
    localparam int C_PC_LD   = C_PC_DRV + 1;
    localparam int C_IR_DRV  = C_PC_DRV + 2;
    localparam int C_IR_LD   = C_PC_DRV + 3;
    localparam int C_Y_LD    = C_PC_DRV + 4;
    localparam int C_Z_DRV   = C_PC_DRV + 5;
    localparam int C_Z_LD    = C_PC_DRV + 6;
    localparam int C_MAR_LD  = C_PC_DRV + 7;
    localparam int C_MDR_DRV = C_PC_DRV + 8;
    localparam int C_MDR_LDB = C_PC_DRV + 9;
    localparam int C_MDR_LDM = C_PC_DRV + 10;
    localparam int C_RD      = C_PC_DRV + 11;
    localparam int C_WR      = C_PC_DRV + 12;
    localparam int C_SEL4    = C_PC_DRV + 13;
    localparam int C_OP      = C_PC_DRV + 14;
    localparam int CTL_W     = C_OP + OP_W;

    // number of bus drivers: general registers plus PC, IR, Z, MDR
    localparam int NDRV      = NGPR + 4;

    typedef enum logic [OP_W-1:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_PASSB = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_READ  = 2'd1,
        MS_WRITE = 2'd2
    } mem_state_e;
endpackage

// File: rtl/sbus_gpr_bank.sv
module sbus_gpr_bank
    import sbus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NREG   = NGPR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   ld,
    input  logic [NREG-1:0]   drv,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] drv_val
);
    logic [DATA_W-1:0] q [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q[g] <= '0;
                else if (ld[g])
                    q[g] <= bus_in;
            end

            assert_gpr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ld[g] |=> q[g] == $past(bus_in));
        end
    endgenerate

    always_comb begin
        drv_val = '0;
        for (int i = 0; i < NREG; i++)
            if (drv[i])
                drv_val = drv_val | q[i];
    end
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/sbus_memctl.sv
module sbus_memctl
    import sbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    input  logic mem_done,
    output logic mem_rd,
    output logic mem_wr,
    output logic mem_wait
);
    mem_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            MS_IDLE: begin
                if (rd_req)
                    state_nx = MS_READ;
                else if (wr_req)
                    state_nx = MS_WRITE;
            end
            MS_READ:  if (mem_done) state_nx = MS_IDLE;
            MS_WRITE: if (mem_done) state_nx = MS_IDLE;
            default:  state_nx = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= MS_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mem_wait = 1'b0;
        unique case (state)
            MS_READ: begin
                mem_rd   = 1'b1;
                mem_wait = !mem_done;
            end
            MS_WRITE: begin
                mem_wr   = 1'b1;
                mem_wait = !mem_done;
            end
            default: ;
        endcase
    end

    assert_rd_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_done) |=> mem_rd);

    assert_wr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_done) |=> mem_wr);

    assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_done && rd_req) |=> !mem_rd);

    assert_wait_in_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wait |-> (mem_rd || mem_wr));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTL_W-1:0]  ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_wait,
    output logic              flag_n,
    output logic              flag_z,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] bus_q
);
    localparam logic [DATA_W-1:0] WORD_STEP = DATA_W'(4);

    logic [DATA_W-1:0] bus, gpr_val, alu_a, alu_y;
    logic [DATA_W-1:0] pc_r, ir_r, y_r, z_r, mar_r, mdr_r;
    logic              n_r, zf_r;
    logic [NDRV-1:0]   drv_all;

    // control field split
    logic [NGPR-1:0] gpr_drv, gpr_ld;
    assign gpr_drv = ctl[C_GDRV +: NGPR];
    assign gpr_ld  = ctl[C_GLD +: NGPR];
    assign drv_all = {ctl[C_MDR_DRV], ctl[C_Z_DRV], ctl[C_IR_DRV], ctl[C_PC_DRV], gpr_drv};

    sbus_gpr_bank #(.DATA_W(DATA_W), .NREG(NGPR)) u_gpr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (gpr_ld),
        .drv    (gpr_drv),
        .bus_in (bus),
        .drv_val(gpr_val)
    );

    // shared bus: one-hot gated sources merged
    always_comb begin
        bus = gpr_val;
        if (ctl[C_PC_DRV])  bus = bus | pc_r;
        if (ctl[C_IR_DRV])  bus = bus | ir_r;
        if (ctl[C_Z_DRV])   bus = bus | z_r;
        if (ctl[C_MDR_DRV]) bus = bus | mdr_r;
    end

    assign alu_a = ctl[C_SEL4] ? WORD_STEP : y_r;

    sbus_alu #(.DATA_W(DATA_W)) u_alu (
        .op(alu_op_e'(ctl[C_OP +: OP_W])),
        .a (alu_a),
        .b (bus),
        .y (alu_y)
    );

    sbus_memctl u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (ctl[C_RD]),
        .wr_req  (ctl[C_WR]),
        .mem_done(mem_done),
        .mem_rd  (mem_rd),
        .mem_wr  (mem_wr),
        .mem_wait(mem_wait)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_r  <= '0;
            ir_r  <= '0;
            y_r   <= '0;
            mar_r <= '0;
        end else begin
            if (ctl[C_PC_LD])  pc_r  <= bus;
            if (ctl[C_IR_LD])  ir_r  <= bus;
            if (ctl[C_Y_LD])   y_r   <= bus;
            if (ctl[C_MAR_LD]) mar_r <= bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            z_r  <= '0;
            n_r  <= 1'b0;
            zf_r <= 1'b0;
        end else if (ctl[C_Z_LD]) begin
            z_r  <= alu_y;
            n_r  <= alu_y[DATA_W-1];
            zf_r <= (alu_y == '0);
        end
    end

    // memory data register: memory side has priority over bus side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mdr_r <= '0;
        else if (ctl[C_MDR_LDM] && mem_done)
            mdr_r <= mem_rdata;
        else if (ctl[C_MDR_LDB])
            mdr_r <= bus;
    end

    assign mem_addr  = mar_r;
    assign mem_wdata = mdr_r;
    assign flag_n    = n_r;
    assign flag_z    = zf_r;
    assign ir_q      = ir_r;
    assign bus_q     = bus;

    assert_single_driver_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drv_all) <= 1);

    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[C_Z_LD] |=> $stable({flag_n, flag_z}));

    assert_mar_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl[C_MAR_LD] |=> mem_addr == $past(bus));

    assert_mar_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[C_MAR_LD] |=> $stable(mem_addr));

    assert_mdr_from_mem_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[C_MDR_LDM] && mem_done) |=> mem_wdata == $past(mem_rdata));
endmodule

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
module sim_sbus_datapath;
    import sbus_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CTL_W-1:0] ctl = '0;
    logic [31:0]      mem_rdata = '0;
    logic             mem_done = 1'b0;
    logic [31:0]      mem_addr, mem_wdata, ir_q, bus_q;
    logic             mem_rd, mem_wr, mem_wait, flag_n, flag_z;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sbus_datapath #(.DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .mem_rdata(mem_rdata), .mem_done(mem_done),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wait(mem_wait), .flag_n(flag_n), .flag_z(flag_z), .ir_q(ir_q), .bus_q(bus_q)
    );

    function automatic logic [CTL_W-1:0] bitv(input int p);
        logic [CTL_W-1:0] v;
        v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    function automatic logic [CTL_W-1:0] opv(input logic [2:0] op);
        logic [CTL_W-1:0] v;
        v = '0;
        v[C_OP +: 3] = op;
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // apply one control step away from the clock edge
    task automatic cyc(input logic [CTL_W-1:0] v, input logic done);
        @(negedge clk);
        ctl = v;
        mem_done = done;
        #1;
    endtask

    task automatic peek(input int pos, output logic [31:0] val);
        cyc(bitv(pos), 1'b0);
        val = bus_q;
    endtask

    task automatic mem_read(input logic [CTL_W-1:0] extra, input logic [31:0] data,
                            input int lat, input logic [31:0] exp_addr);
        cyc(extra | bitv(C_MAR_LD) | bitv(C_RD), 1'b0);
        for (int i = 0; i < lat; i++) begin
            cyc(bitv(C_MDR_LDM), 1'b0);
            chk("R8 rd strobe", {31'b0, mem_rd}, 32'd1);
            chk("R8 wait", {31'b0, mem_wait}, 32'd1);
            chk("R7 addr", mem_addr, exp_addr);
        end
        mem_rdata = data;
        cyc(bitv(C_MDR_LDM), 1'b1);
        chk("R8 wait on done", {31'b0, mem_wait}, 32'd0);
        cyc('0, 1'b0);
        chk("R8 rd released", {31'b0, mem_rd}, 32'd0);
        chk("R8 mdr captured", mem_wdata, data);
    endtask

    task automatic seed(input int r, input logic [31:0] val);
        mem_read('0, val, 1, 32'd0);
        cyc(bitv(C_MDR_DRV) | bitv(C_GLD + r), 1'b0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int r = 0; r < NGPR; r++) begin
            peek(C_GDRV + r, v);
            chk("R1 gpr zero", v, 32'd0);
        end
        peek(C_PC_DRV, v);  chk("R1 pc zero", v, 32'd0);
        peek(C_IR_DRV, v);  chk("R1 ir zero", v, 32'd0);
        peek(C_Z_DRV, v);   chk("R1 z zero", v, 32'd0);
        peek(C_MDR_DRV, v); chk("R1 mdr zero", v, 32'd0);
        chk("R1 flags", {30'b0, flag_n, flag_z}, 32'd0);
        chk("R1 strobes", {29'b0, mem_rd, mem_wr, mem_wait}, 32'd0);
        chk("R1 mar", mem_addr, 32'd0);
        cyc('0, 1'b0);
        chk("R3 idle bus zero", bus_q, 32'd0);
    endtask

    task automatic t_move();
        logic [31:0] v;
        seed(1, 32'h10);
        seed(2, 32'h7);
        peek(C_GDRV + 1, v); chk("R2 r1 seeded", v, 32'h10);
        peek(C_GDRV + 2, v); chk("R3 r2 on bus", v, 32'h7);
        cyc(bitv(C_GDRV + 1) | bitv(C_GLD + 5), 1'b0);
        peek(C_GDRV + 5, v); chk("R2 r1 to r5", v, 32'h10);
    endtask

    task automatic t_add();
        logic [31:0] v;
        cyc(bitv(C_GDRV + 1) | bitv(C_Y_LD), 1'b0);
        cyc(bitv(C_GDRV + 2) | opv(3'd0) | bitv(C_Z_LD), 1'b0);
        cyc(bitv(C_Z_DRV) | bitv(C_GLD + 3), 1'b0);
        peek(C_GDRV + 3, v);
        chk("R12 three step add", v, 32'h17);
        chk("R6 flags after add", {30'b0, flag_n, flag_z}, 32'd0);
    endtask

    task automatic t_ops();
        logic [31:0] v, zkeep;
        cyc(bitv(C_GDRV + 2) | bitv(C_Y_LD), 1'b0);     // Y = 7
        cyc(bitv(C_GDRV + 1) | opv(3'd1) | bitv(C_Z_LD), 1'b0);
        peek(C_Z_DRV, v); chk("R5 sub", v, 32'hFFFF_FFF7);
        chk("R6 negative flag", {30'b0, flag_n, flag_z}, 32'd2);
        cyc(bitv(C_GDRV + 1) | opv(3'd2) | bitv(C_Z_LD), 1'b0);
        peek(C_Z_DRV, v); chk("R5 and", v, 32'h0);
        chk("R6 zero flag", {30'b0, flag_n, flag_z}, 32'd1);
        zkeep = v;
        cyc(bitv(C_GDRV + 1) | opv(3'd3), 1'b0);           // no Z load
        peek(C_Z_DRV, v); chk("R6 z held", v, zkeep);
        chk("R6 flags held", {30'b0, flag_n, flag_z}, 32'd1);
        cyc(bitv(C_GDRV + 1) | opv(3'd3) | bitv(C_Z_LD), 1'b0);
        peek(C_Z_DRV, v); chk("R5 or", v, 32'h17);
        cyc(bitv(C_GDRV + 1) | opv(3'd4) | bitv(C_Z_LD), 1'b0);
        peek(C_Z_DRV, v); chk("R5 pass b", v, 32'h10);
        cyc(bitv(C_GDRV + 2) | opv(3'd7) | bitv(C_Z_LD), 1'b0);
        peek(C_Z_DRV, v); chk("R5 code 7 pass b", v, 32'h7);
        chk("R6 flags clear", {30'b0, flag_n, flag_z}, 32'd0);
    endtask

    task automatic t_pc();
        logic [31:0] v;
        for (int k = 1; k <= 2; k++) begin
            cyc(bitv(C_PC_DRV) | bitv(C_SEL4) | opv(3'd0) | bitv(C_Z_LD), 1'b0);
            cyc(bitv(C_Z_DRV) | bitv(C_PC_LD), 1'b0);
            peek(C_PC_DRV, v);
            chk("R4 pc plus four", v, 32'(4 * k));
        end
    endtask

    task automatic t_mar();
        cyc(bitv(C_GDRV + 3) | bitv(C_MAR_LD), 1'b0);
        cyc(bitv(C_GDRV + 1) | bitv(C_Y_LD), 1'b0);
        chk("R7 mar loaded", mem_addr, 32'h17);
        cyc(bitv(C_GDRV + 2), 1'b0);
        chk("R7 mar held", mem_addr, 32'h17);
    endtask

    task automatic t_write();
        logic [31:0] v;
        cyc(bitv(C_GDRV + 3) | bitv(C_MDR_LDB), 1'b0);
        peek(C_MDR_DRV, v); chk("R11 mdr from bus", v, 32'h17);
        cyc(bitv(C_WR), 1'b0);
        cyc('0, 1'b0);
        chk("R9 wr strobe", {31'b0, mem_wr}, 32'd1);
        chk("R9 wdata", mem_wdata, 32'h17);
        chk("R9 wait", {31'b0, mem_wait}, 32'd1);
        cyc(bitv(C_RD), 1'b0);                               // ignored while busy
        chk("R10 no read while writing", {31'b0, mem_rd}, 32'd0);
        cyc('0, 1'b1);
        chk("R9 wait drops on done", {31'b0, mem_wait}, 32'd0);
        cyc('0, 1'b0);
        chk("R10 busy read dropped", {30'b0, mem_rd, mem_wr}, 32'd0);
        cyc(bitv(C_RD) | bitv(C_WR), 1'b0);
        cyc('0, 1'b0);
        chk("R10 read wins", {30'b0, mem_rd, mem_wr}, 32'd2);
        cyc('0, 1'b1);
        cyc('0, 1'b0);
        chk("R10 back to idle", {30'b0, mem_rd, mem_wr}, 32'd0);
    endtask

    task automatic t_mdr_prio();
        logic [31:0] v;
        cyc(bitv(C_GDRV + 2) | bitv(C_MAR_LD) | bitv(C_RD), 1'b0);
        cyc(bitv(C_MDR_LDM), 1'b0);
        chk("R8 latency addr", mem_addr, 32'h7);
        mem_rdata = 32'hCAFE_0042;
        cyc(bitv(C_GDRV + 1) | bitv(C_MDR_LDB) | bitv(C_MDR_LDM), 1'b1);
        cyc('0, 1'b0);
        peek(C_MDR_DRV, v); chk("R11 memory beats bus", v, 32'hCAFE_0042);
        mem_read('0, 32'h8000_1234, 3, 32'h0);
        cyc(bitv(C_MDR_DRV) | bitv(C_IR_LD), 1'b0);
        cyc('0, 1'b0);
        chk("R2 ir loaded", ir_q, 32'h8000_1234);
        peek(C_IR_DRV, v); chk("R3 ir on bus", v, 32'h8000_1234);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_move();
        t_add();
        t_ops();
        t_pc();
        t_mar();
        t_write();
        t_mdr_prio();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual %h expected %h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule